// File: doc/BRIEF.md
# Absolute-to-Physical Address Mapper

This block turns a 64-bit absolute address into a physical address for a processor whose virtual translation is switched off. Each request carries two mode bits. The wide-mode bit selects the 64-bit addressing view. The architecture-level bit tells a newer implementation apart from a legacy one.

In wide mode the address is cut down to the physical width and sign-extended. In narrow mode on the newer level, the low 32 bits are sorted into one of three regions by their top two nibbles: memory, I/O or firmware. Each region has its own extension rule. In narrow mode on the legacy level, the low 32 bits are zero-extended and no region decode takes place.

The block is a single registered stage. One cycle after a valid request it presents the 64-bit mapped address, a region tag and the access permission that applies with translation off. The physical width `PA_W` is a parameter and must be no more than 54 bits.

Top module: `abs_phys_map`

## Requirements
- R1: `out_valid` is high in exactly the cycle after a cycle in which `in_valid` was high, and is low after reset. Reset also clears `out_paddr`, `out_region` and `out_perm` to zero.
- R2: With `in_wide`=1, `out_paddr` is `in_addr[PA_W-1:0]` sign-extended from bit `PA_W-1` to 64 bits, and `out_region` is 0 (memory).
- R3: With `in_wide`=0, `in_newarch`=1 and `in_addr[31:28]` not equal to 4'hF, `out_paddr` is `in_addr[31:0]` zero-extended, and `out_region` is 0 (memory).
- R4: With `in_wide`=0, `in_newarch`=1, `in_addr[31:28]`=4'hF and `in_addr[27:24]` not zero, `out_paddr` is `in_addr[31:0]` sign-extended to 64 bits, and `out_region` is 1 (I/O).
- R5: With `in_wide`=0, `in_newarch`=1, `in_addr[31:28]`=4'hF and `in_addr[27:24]`=0, `out_paddr` is `in_addr[31:0]` zero-extended with ones ORed into every bit from `PA_W-4` through 63, and `out_region` is 2 (firmware).
- R6: With `in_wide`=0 and `in_newarch`=0, `out_paddr` is `in_addr[31:0]` zero-extended and `out_region` is 0, whatever the nibble values.
- R7: Every result carries `out_perm`=3'b111 (bit 2 read, bit 1 write, bit 0 execute).
- R8: While `in_valid` is low, `out_paddr`, `out_region` and `out_perm` keep their last values.
- R9: In wide mode the result does not depend on `in_newarch` or on `in_addr` bits at or above `PA_W`.
- R10: `out_region` never takes the value 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_addr | input | 64 | Absolute address |
| in_wide | input | 1 | 1 = wide (64-bit) addressing view |
| in_newarch | input | 1 | 1 = newer architecture level, 0 = legacy |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_paddr | output | 64 | Mapped physical address |
| out_region | output | 2 | 0 memory, 1 I/O, 2 firmware |
| out_perm | output | 3 | Permission: read, write, execute |

## Verification
Two things can meet on the same clock edge. One is the capture of a new result into the output stage. The other is the hold of the previous result, which must survive when the request strobe drops.

The bench provokes this in two ways. It sends back-to-back requests that switch between wide, narrow and legacy modes on consecutive cycles, and it sends isolated pulses separated by idle gaps. A scoreboard checks each emitted result against an independently computed expectation. On every idle cycle it also confirms that the outputs still equal the last expected result, so any capture that leaks across a mode change or into an idle cycle is caught.

// File: rtl/abs_map_pkg.sv
package abs_map_pkg;

    localparam int ABS_W    = 64;
    localparam int NARROW_W = 32;

    typedef enum logic [1:0] {
        RGN_MEM  = 2'd0,
        RGN_IO   = 2'd1,
        RGN_FIRM = 2'd2
    } region_e;

    localparam logic [2:0] PERM_RWX = 3'b111;

    typedef struct packed {
        logic [ABS_W-1:0] paddr;
        region_e          region;
        logic [2:0]       perm;
    } map_result_t;

    // Region of a narrow address on the newer architecture level.
    function automatic region_e narrow_region(input logic [NARROW_W-1:0] a);
        if (a[31:28] != 4'hF)      return RGN_MEM;
        else if (a[27:24] != 4'h0) return RGN_IO;
        else                       return RGN_FIRM;
    endfunction

endpackage

// File: rtl/amap_wide_path.sv
module amap_wide_path
    import abs_map_pkg::*;
#(
    parameter int PA_W = 40
) (
    input  logic [PA_W-1:0]  addr,
    output logic [ABS_W-1:0] paddr
);
    localparam int EXT_W = ABS_W - PA_W;

    // Truncate to the physical width, then replicate its top bit.
    assign paddr = {{EXT_W{addr[PA_W-1]}}, addr};
endmodule

// File: rtl/amap_narrow_path.sv
module amap_narrow_path
    import abs_map_pkg::*;
#(
    parameter int PA_W = 40
) (
    input  logic [NARROW_W-1:0] addr,
    input  logic                newarch,
    output logic [ABS_W-1:0]    paddr,
    output region_e             region
);
    localparam int               FW_LSB  = PA_W - 4;
    localparam logic [ABS_W-1:0] FW_MASK = {ABS_W{1'b1}} << FW_LSB;
    localparam int               HI_W    = ABS_W - NARROW_W;

    region_e          decoded;
    logic [ABS_W-1:0] zext;
    logic [ABS_W-1:0] sext;

    assign decoded = narrow_region(addr);
    assign zext    = {{HI_W{1'b0}}, addr};
    assign sext    = {{HI_W{addr[NARROW_W-1]}}, addr};

    always_comb begin
        if (!newarch) begin
            paddr  = zext;
            region = RGN_MEM;
        end else begin
            region = decoded;
            unique case (decoded)
                RGN_IO:   paddr = sext;
                RGN_FIRM: paddr = zext | FW_MASK;
                default:  paddr = zext;
            endcase
        end
    end
endmodule

// File: rtl/amap_result_reg.sv
module amap_result_reg
    import abs_map_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  map_result_t d,
    output logic        valid,
    output map_result_t q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            q     <= '0;
        end else begin
            valid <= load;
            if (load) q <= d;
        end
    end
endmodule

// File: rtl/abs_phys_map.sv
module abs_phys_map
    import abs_map_pkg::*;
#(
    parameter int PA_W = 40
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [63:0] in_addr,
    input  logic        in_wide,
    input  logic        in_newarch,
    output logic        out_valid,
    output logic [63:0] out_paddr,
    output logic [1:0]  out_region,
    output logic [2:0]  out_perm
);
    logic [ABS_W-1:0] wide_pa;
    logic [ABS_W-1:0] narrow_pa;
    region_e          narrow_rg;
    map_result_t      next_res;
    map_result_t      cur_res;

    amap_wide_path #(.PA_W(PA_W)) wide_i (
        .addr  (in_addr[PA_W-1:0]),
        .paddr (wide_pa)
    );

    amap_narrow_path #(.PA_W(PA_W)) narrow_i (
        .addr    (in_addr[NARROW_W-1:0]),
        .newarch (in_newarch),
        .paddr   (narrow_pa),
        .region  (narrow_rg)
    );

    always_comb begin
        next_res.perm = PERM_RWX;
        if (in_wide) begin
            next_res.paddr  = wide_pa;
            next_res.region = RGN_MEM;
        end else begin
            next_res.paddr  = narrow_pa;
            next_res.region = narrow_rg;
        end
    end

    amap_result_reg out_i (
        .clk   (clk),
        .rst   (rst),
        .load  (in_valid),
        .d     (next_res),
        .valid (out_valid),
        .q     (cur_res)
    );

    assign out_paddr  = cur_res.paddr;
    assign out_region = cur_res.region;
    assign out_perm   = cur_res.perm;
endmodule

// File: rtl/amap_checker.sv
module amap_checker #(
    parameter int PA_W = 40
) (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [63:0] in_addr,
    input logic        in_wide,
    input logic        in_newarch,
    input logic        out_valid,
    input logic [63:0] out_paddr,
    input logic [1:0]  out_region,
    input logic [2:0]  out_perm
);
    logic narrow_new;
    assign narrow_new = in_valid && !in_wide && in_newarch;

    initial begin
        assert_width_range: assert (PA_W <= 54 && PA_W > 4);
    end

    assert_valid_rise_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    assert_valid_low_R1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    assert_wide_ext_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_wide) |=>
            ((out_paddr[63:PA_W-1] == '0) || (out_paddr[63:PA_W-1] == '1))
            && out_paddr[PA_W-2:0] == $past(in_addr[PA_W-2:0])
            && out_region == 2'd0);
    assert_mem_zext_R3: assert property (@(posedge clk) disable iff (rst)
        (narrow_new && in_addr[31:28] != 4'hF) |=>
            out_paddr == {32'h0, $past(in_addr[31:0])} && out_region == 2'd0);
    assert_io_sext_R4: assert property (@(posedge clk) disable iff (rst)
        (narrow_new && in_addr[31:28] == 4'hF && in_addr[27:24] != 4'h0) |=>
            out_paddr[63:32] == 32'hFFFF_FFFF && out_region == 2'd1);
    assert_firm_tag_R5: assert property (@(posedge clk) disable iff (rst)
        (narrow_new && in_addr[31:24] == 8'hF0) |=>
            out_region == 2'd2 && out_paddr[63:PA_W-4] == '1);
    assert_legacy_zext_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_wide && !in_newarch) |=>
            out_paddr[63:32] == 32'h0 && out_region == 2'd0);
    assert_perm_full_R7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_perm == 3'b111);
    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_paddr) && $stable(out_region) && $stable(out_perm));
    assert_tag_legal_R10: assert property (@(posedge clk) disable iff (rst)
        out_region != 2'd3);
endmodule

bind abs_phys_map amap_checker #(.PA_W(PA_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_addr    (in_addr),
    .in_wide    (in_wide),
    .in_newarch (in_newarch),
    .out_valid  (out_valid),
    .out_paddr  (out_paddr),
    .out_region (out_region),
    .out_perm   (out_perm)
);

// File: tb/abs_phys_map_tb_top.sv
module abs_phys_map_tb_top;
    localparam int PA_W = 40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] in_addr = '0;
    logic        in_wide = 1'b0;
    logic        in_newarch = 1'b0;
    logic        out_valid;
    logic [63:0] out_paddr;
    logic [1:0]  out_region;
    logic [2:0]  out_perm;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    typedef struct {
        logic [63:0] pa;
        logic [1:0]  rg;
        string       req;
    } exp_t;

    exp_t q[$];
    exp_t last;
    bit   have_last = 0;

    always #5 clk = ~clk;

    abs_phys_map #(.PA_W(PA_W)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_addr(in_addr),
        .in_wide(in_wide), .in_newarch(in_newarch), .out_valid(out_valid),
        .out_paddr(out_paddr), .out_region(out_region), .out_perm(out_perm)
    );

    function automatic exp_t model(logic [63:0] a, logic w, logic na);
        exp_t e;
        logic signed [63:0] t;
        if (w) begin
            t = a << (64 - PA_W);
            t = t >>> (64 - PA_W);
            e.pa = t; e.rg = 2'd0; e.req = "R2";
        end else if (!na) begin
            e.pa = {32'h0, a[31:0]}; e.rg = 2'd0; e.req = "R6";
        end else if (a[31:28] != 4'hF) begin
            e.pa = {32'h0, a[31:0]}; e.rg = 2'd0; e.req = "R3";
        end else if (a[27:24] != 4'h0) begin
            t = {a[31:0], 32'h0};
            t = t >>> 32;
            e.pa = t; e.rg = 2'd1; e.req = "R4";
        end else begin
            e.pa = {32'h0, a[31:0]};
            for (int b = PA_W - 4; b < 64; b++) e.pa[b] = 1'b1;
            e.rg = 2'd2; e.req = "R5";
        end
        return e;
    endfunction

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send(logic [63:0] a, logic w, logic na);
        @(negedge clk);
        in_valid = 1'b1; in_addr = a; in_wide = w; in_newarch = na;
        q.push_back(model(a, w, na));
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_addr = 64'hA5A5_5A5A_DEAD_BEEF ^ 64'(i);
            in_wide = i[0];
            in_newarch = i[1];
        end
    endtask

    // Monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && !done) begin
                if (out_valid) begin
                    if (q.size() == 0) begin
                        check(0, "R1 spurious out_valid", 64'(out_valid), 64'd0);
                    end else begin
                        exp_t e;
                        e = q.pop_front();
                        check(out_paddr == e.pa, e.req, out_paddr, e.pa);
                        check(out_region == e.rg, {e.req, " R10 region"},
                              64'(out_region), 64'(e.rg));
                        check(out_perm == 3'b111, "R7 perm",
                              64'(out_perm), 64'd7);
                        last = e; have_last = 1;
                    end
                end else if (have_last) begin
                    check(out_paddr == last.pa && out_region == last.rg
                          && out_perm == 3'b111, "R8 hold", out_paddr, last.pa);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] r;
        r = 64'h1234_5678_9ABC_DEF1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check(out_valid == 0, "R1 reset valid", 64'(out_valid), 0);
        check(out_paddr == 0 && out_region == 0 && out_perm == 0,
              "R1 reset data", out_paddr, 0);

        // R2 wide: top bit of the physical width set / clear, junk above
        send(64'h0000_0080_0000_0001, 1, 1);
        send(64'hFFFF_FF00_1234_5678, 1, 0);   // R9 high junk dropped
        idle(2);
        send(64'h5555_5580_0000_0000, 1, 0);   // R9 both arch values
        send(64'h5555_5580_0000_0000, 1, 1);
        // R3 memory region, junk in upper half
        send(64'hDEAD_BEEF_1234_5678, 0, 1);
        send(64'h0000_0000_EFFF_FFFF, 0, 1);
        // R4 I/O region edges
        send(64'h0000_0000_F100_0000, 0, 1);
        send(64'hFFFF_0000_FFFF_FFFF, 0, 1);
        idle(1);
        // R5 firmware region edges
        send(64'h0000_0000_F000_0000, 0, 1);
        send(64'h1111_1111_F0FF_FFFF, 0, 1);
        // R6 legacy: same patterns, no decode
        send(64'h1111_1111_F000_1234, 0, 0);
        send(64'h0000_0000_F800_0000, 0, 0);
        send(64'h0000_0000_7000_0000, 0, 0);
        idle(3);
        // Mixed back-to-back mode flips
        for (int i = 0; i < 300; i++) begin
            logic [63:0] a;
            r = r ^ (r << 13); r = r ^ (r >> 7); r = r ^ (r << 17);
            a = r;
            if (r[5:4] == 2'd0) a[31:28] = 4'hF;
            if (r[7:6] == 2'd0) a[27:24] = 4'h0;
            send(a, r[40] & r[41], r[42] | r[43]);
            if (r[50:48] == 3'd0) idle(int'(r[53:52]) + 1);
        end
        idle(3);
        check(q.size() == 0, "R1 results outstanding", 64'(q.size()), 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule